// File: doc/BRIEF.md
# USB Full-Speed Link State Monitor

This block follows the link state of a full-speed USB device. Its inputs are the bus-power sense, a device-enable bit, a two-bit line code that an upstream receiver decodes from the D+/D- pair at the 48 MHz sample rate, and a strobe that marks each received start-of-frame packet. It keeps a five-state link machine and gives out its state code. It also gives one-cycle event pulses when the device disconnects, when the host resets the link, when the link goes idle into suspend, when the link resumes, and when frame markers stop arriving during normal operation.

The block has a second output path that serves as a timing reference for trimming the local clock. A pulse marks each frame marker. A valid flag goes with it and drops as soon as a frame marker is overdue. A disable input holds both of these outputs at zero. Every timing threshold is a parameter counted in clock cycles. The defaults match a 48 MHz clock: 3 us for reset, 3 ms for suspend, 4.096 ms for host loss and 1.5 ms for the reference timeout.

Top module: `usb_link_monitor`

## Requirements
- R1: During reset and in the first cycle after it, the state code is 0 (Disconnect) and every event, pulse and valid output is 0. The state codes are: 0 Disconnect, 1 Powered, 2 Powered-Suspend, 3 Active, 4 Suspend.
- R2: When sense or enable is low at a clock edge, the state is Disconnect one cycle later. The disconnect event pulses for exactly that one cycle, and only if the previous state was not Disconnect.
- R3: When sense and enable are both high in the Disconnect state, the state moves to Powered one cycle later, with no event.
- R4: In any state other than Disconnect, the reset event fires when the line code has been 0 (SE0) for RESET_CYCLES consecutive samples. It then moves Powered, Powered-Suspend, Active or Suspend to Active. It fires once per unbroken SE0 period.
- R5: In Powered or Active, the suspend event fires when the line code has been 1 (J) for SUSPEND_CYCLES consecutive samples. The state then goes to Powered-Suspend from Powered and to Suspend from Active.
- R6: In Powered-Suspend or Suspend, a line code other than 1 fires the resume event one cycle later. Suspend returns to Active and Powered-Suspend returns to Powered.
- R7: While Active, HOSTLOST_CYCLES consecutive cycles with no frame strobe fire the host-lost event once, and the state is unchanged. Each frame strobe restarts that count.
- R8: Each frame strobe sampled while the reference disable is low gives a one-cycle reference pulse one cycle later. The valid flag is high from that same cycle onward.
- R9: After REFLOST_CYCLES consecutive cycles with no frame strobe, the valid flag goes low. It stays low until the next reference pulse.
- R10: While the reference disable is high, the reference pulse and the valid flag are 0 from the next cycle on. The valid flag stays 0 until a later pulse.
- R11: A timed condition that breaks before its threshold restarts its count from zero. The link machine gives at most one of its four events in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock (48 MHz nominal) |
| rst_i | input | 1 | Synchronous active-high reset |
| sense_i | input | 1 | Bus power present |
| enable_i | input | 1 | Device enabled |
| line_i | input | 2 | Decoded line: 0 SE0, 1 J, 2 or 3 other |
| sof_i | input | 1 | One-cycle frame-marker received strobe |
| ref_disable_i | input | 1 | Forces the reference outputs to zero |
| link_state_o | output | 3 | Link state code |
| ev_disconnect_o | output | 1 | Disconnect event pulse |
| ev_reset_o | output | 1 | Link reset event pulse |
| ev_suspend_o | output | 1 | Suspend event pulse |
| ev_resume_o | output | 1 | Resume event pulse |
| ev_host_lost_o | output | 1 | Host-lost event pulse |
| ref_pulse_o | output | 1 | Frame reference pulse |
| ref_valid_o | output | 1 | Reference pulse valid flag |

## Verification
The bench predicts the exact cycle of every event. An off-by-one in a threshold counter therefore shows up as a mismatched timestamp, not as a late but plausible pulse. It holds SE0 for one cycle less than the threshold and then restarts it. A counter that kept its count would fire early. It also leaves SE0 held after a reset, and a detector that did not stop after one hit would pulse again. Suspend is entered both before and after a reset and left through each path. A machine that merged the two suspend states would return to the wrong state. The bench lets the frame strobe lapse long enough to drop the valid flag and also fire host-lost, then restores it, then pulses it under disable. A flag that came back by itself, or leaked through the disable, shows up at the ports.

// File: rtl/usb_lsm_pkg.sv
package usb_lsm_pkg;

  typedef enum logic [2:0] {
    LINK_DISCONNECT   = 3'd0,
    LINK_POWERED      = 3'd1,
    LINK_POWERED_SUSP = 3'd2,
    LINK_ACTIVE       = 3'd3,
    LINK_SUSPEND      = 3'd4
  } link_state_e;

  localparam logic [1:0] LINE_SE0 = 2'd0;
  localparam logic [1:0] LINE_J   = 2'd1;

endpackage

// File: rtl/usb_lsm_hold_timer.sv
// Counts consecutive cycles of a condition; one-cycle hit when LIMIT reached.
module usb_lsm_hold_timer #(
  parameter int LIMIT = 144
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic cond_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          hit_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else if (!cond_i) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      hit_q <= (cnt_q == LAST);
      if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit_o = hit_q;

  // R11: a hit lasts a single cycle and the count never passes the limit
  p_hit_single_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_q |=> !hit_q);
  p_cnt_bound_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= TOP);
  p_hit_needs_cond_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    !cond_i |=> !hit_q);

endmodule

// File: rtl/usb_lsm_fsm.sv
module usb_lsm_fsm
  import usb_lsm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        connected_i,
  input  logic [1:0]  line_i,
  input  logic        hit_reset_i,
  input  logic        hit_suspend_i,
  output link_state_e state_o,
  output logic        ev_disconnect_o,
  output logic        ev_reset_o,
  output logic        ev_suspend_o,
  output logic        ev_resume_o
);
  link_state_e state_q, state_d;
  logic ev_disc_d, ev_rst_d, ev_susp_d, ev_res_d;
  logic ev_disc_q, ev_rst_q, ev_susp_q, ev_res_q;
  logic line_not_j;

  assign line_not_j = (line_i != LINE_J);

  always_comb begin
    state_d   = state_q;
    ev_disc_d = 1'b0;
    ev_rst_d  = 1'b0;
    ev_susp_d = 1'b0;
    ev_res_d  = 1'b0;
    if (!connected_i) begin
      state_d   = LINK_DISCONNECT;
      ev_disc_d = (state_q != LINK_DISCONNECT);
    end else begin
      unique case (state_q)
        LINK_DISCONNECT: state_d = LINK_POWERED;
        LINK_POWERED: begin
          if (hit_reset_i) begin
            state_d  = LINK_ACTIVE;
            ev_rst_d = 1'b1;
          end else if (hit_suspend_i) begin
            state_d   = LINK_POWERED_SUSP;
            ev_susp_d = 1'b1;
          end
        end
        LINK_POWERED_SUSP: begin
          if (hit_reset_i) begin
            state_d  = LINK_ACTIVE;
            ev_rst_d = 1'b1;
          end else if (line_not_j) begin
            state_d  = LINK_POWERED;
            ev_res_d = 1'b1;
          end
        end
        LINK_ACTIVE: begin
          if (hit_reset_i) begin
            ev_rst_d = 1'b1;
          end else if (hit_suspend_i) begin
            state_d   = LINK_SUSPEND;
            ev_susp_d = 1'b1;
          end
        end
        LINK_SUSPEND: begin
          if (hit_reset_i) begin
            state_d  = LINK_ACTIVE;
            ev_rst_d = 1'b1;
          end else if (line_not_j) begin
            state_d  = LINK_ACTIVE;
            ev_res_d = 1'b1;
          end
        end
        default: state_d = LINK_DISCONNECT;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q   <= LINK_DISCONNECT;
      ev_disc_q <= 1'b0;
      ev_rst_q  <= 1'b0;
      ev_susp_q <= 1'b0;
      ev_res_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      ev_disc_q <= ev_disc_d;
      ev_rst_q  <= ev_rst_d;
      ev_susp_q <= ev_susp_d;
      ev_res_q  <= ev_res_d;
    end
  end

  assign state_o         = state_q;
  assign ev_disconnect_o = ev_disc_q;
  assign ev_reset_o      = ev_rst_q;
  assign ev_suspend_o    = ev_susp_q;
  assign ev_resume_o     = ev_res_q;

  p_disc_state_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !connected_i |=> state_q == LINK_DISCONNECT);
  p_disc_single_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_disc_q |=> !ev_disc_q);
  p_powered_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == LINK_DISCONNECT && connected_i) |=> state_q == LINK_POWERED);
  p_reset_active_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_rst_q |-> state_q == LINK_ACTIVE);
  p_susp_target_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_susp_q |-> (state_q == LINK_SUSPEND || state_q == LINK_POWERED_SUSP));
  p_resume_target_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_res_q |-> (state_q == LINK_ACTIVE || state_q == LINK_POWERED));
  p_one_event_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({ev_disc_q, ev_rst_q, ev_susp_q, ev_res_q}));

endmodule

// File: rtl/usb_lsm_sofref.sv
module usb_lsm_sofref #(
  parameter int REFLOST_CYCLES = 72000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sof_i,
  input  logic disable_i,
  output logic pulse_o,
  output logic valid_o
);
  logic gap_hit;
  logic pulse_q, valid_q;

  usb_lsm_hold_timer #(.LIMIT(REFLOST_CYCLES)) u_gap (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .cond_i (!sof_i),
    .hit_o  (gap_hit)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pulse_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      pulse_q <= sof_i && !disable_i;
      if (disable_i)    valid_q <= 1'b0;
      else if (sof_i)   valid_q <= 1'b1;
      else if (gap_hit) valid_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;
  assign valid_o = valid_q;

  p_pulse_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (sof_i && !disable_i) |=> pulse_q);
  p_valid_rise_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(valid_q) |-> pulse_q);
  p_disable_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    disable_i |=> (!pulse_q && !valid_q));

endmodule

// File: rtl/usb_link_monitor.sv
module usb_link_monitor
  import usb_lsm_pkg::*;
#(
  parameter int RESET_CYCLES    = 144,
  parameter int SUSPEND_CYCLES  = 144000,
  parameter int HOSTLOST_CYCLES = 196608,
  parameter int REFLOST_CYCLES  = 72000
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       sense_i,
  input  logic       enable_i,
  input  logic [1:0] line_i,
  input  logic       sof_i,
  input  logic       ref_disable_i,
  output logic [2:0] link_state_o,
  output logic       ev_disconnect_o,
  output logic       ev_reset_o,
  output logic       ev_suspend_o,
  output logic       ev_resume_o,
  output logic       ev_host_lost_o,
  output logic       ref_pulse_o,
  output logic       ref_valid_o
);
  link_state_e state;
  logic        attached;
  logic        hit_se0, hit_idle, hit_lost;
  logic        host_lost_q;

  assign attached = (state != LINK_DISCONNECT);

  usb_lsm_hold_timer #(.LIMIT(RESET_CYCLES)) u_se0 (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .cond_i (attached && (line_i == LINE_SE0)),
    .hit_o  (hit_se0)
  );

  usb_lsm_hold_timer #(.LIMIT(SUSPEND_CYCLES)) u_idle (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .cond_i (attached && (line_i == LINE_J)),
    .hit_o  (hit_idle)
  );

  usb_lsm_hold_timer #(.LIMIT(HOSTLOST_CYCLES)) u_frame (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .cond_i ((state == LINK_ACTIVE) && !sof_i),
    .hit_o  (hit_lost)
  );

  usb_lsm_fsm u_fsm (
    .clk_i           (clk_i),
    .rst_i           (rst_i),
    .connected_i     (sense_i && enable_i),
    .line_i          (line_i),
    .hit_reset_i     (hit_se0),
    .hit_suspend_i   (hit_idle),
    .state_o         (state),
    .ev_disconnect_o (ev_disconnect_o),
    .ev_reset_o      (ev_reset_o),
    .ev_suspend_o    (ev_suspend_o),
    .ev_resume_o     (ev_resume_o)
  );

  usb_lsm_sofref #(.REFLOST_CYCLES(REFLOST_CYCLES)) u_ref (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .sof_i     (sof_i),
    .disable_i (ref_disable_i),
    .pulse_o   (ref_pulse_o),
    .valid_o   (ref_valid_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) host_lost_q <= 1'b0;
    else       host_lost_q <= hit_lost;
  end

  assign ev_host_lost_o = host_lost_q;
  assign link_state_o   = state;

  p_host_lost_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    host_lost_q |=> !host_lost_q);
  p_host_lost_sof_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    sof_i |=> ##1 !host_lost_q);

endmodule

// File: tb/usb_link_monitor_tb.sv
module usb_link_monitor_tb;
  localparam int RST = 8;
  localparam int SUS = 40;
  localparam int HL  = 60;
  localparam int RL  = 30;

  localparam int K_DISC = 0, K_RST = 1, K_SUS = 2, K_RES = 3, K_LOST = 4;
  localparam int S_DISC = 0, S_PWR = 1, S_PSUS = 2, S_ACT = 3, S_SUS = 4;

  logic clk = 0, rst = 1;
  logic sense = 0, enable = 0, sof = 0, rdis = 0;
  logic [1:0] line = 2'd1;
  logic [2:0] st;
  logic e_disc, e_rst, e_sus, e_res, e_lost, rpulse, rvalid;

  usb_link_monitor #(.RESET_CYCLES(RST), .SUSPEND_CYCLES(SUS),
                     .HOSTLOST_CYCLES(HL), .REFLOST_CYCLES(RL)) u_dut (
    .clk_i(clk), .rst_i(rst), .sense_i(sense), .enable_i(enable),
    .line_i(line), .sof_i(sof), .ref_disable_i(rdis),
    .link_state_o(st), .ev_disconnect_o(e_disc), .ev_reset_o(e_rst),
    .ev_suspend_o(e_sus), .ev_resume_o(e_res), .ev_host_lost_o(e_lost),
    .ref_pulse_o(rpulse), .ref_valid_o(rvalid));

  always #5 clk = ~clk;

  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int kind; int at; int st; } exp_t;
  exp_t exp_q[$];
  exp_t got;

  function automatic string tag(int k);
    case (k)
      K_DISC: return "R2";
      K_RST:  return "R4";
      K_SUS:  return "R5";
      K_RES:  return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic push(int k, int at, int s);
    exp_t e;
    e.kind = k; e.at = at; e.st = s;
    exp_q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard as event pulses appear
  wire [4:0] evs = {e_lost, e_res, e_sus, e_rst, e_disc};
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int k = 0; k < 5; k++) begin
        if (evs[k]) begin
          if (exp_q.size() == 0) begin
            check(1'b0, tag(k), k, -1);
          end else begin
            got = exp_q.pop_front();
            check(got.kind == k, tag(got.kind), k, got.kind);
            check(got.at == cyc, tag(got.kind), cyc, got.at);
            check(int'(st) == got.st, tag(got.kind), int'(st), got.st);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) if (cyc > 5000) begin
    errors++;
    $display("FAIL watchdog actual=%0d expected=<5000", cyc);
    finish_run();
  end

  initial begin
    int c, r0, c2, c3;
    tick(3);
    rst = 0;
    tick(1);
    // R1: reset state
    check(st == 3'd0, "R1", st, 0);
    check(evs == 5'd0 && !rpulse && !rvalid, "R1", {evs, rpulse, rvalid}, 0);

    // R3, R5: attach with line idle -> Powered then Powered-Suspend
    c = cyc; sense = 1; enable = 1;
    push(K_SUS, c + SUS + 2, S_PSUS);
    tick(1);
    check(st == 3'(S_PWR), "R3", st, S_PWR);
    wait_until(c + SUS + 4);
    check(st == 3'(S_PSUS), "R5", st, S_PSUS);

    // R6: resume to Powered; R4: reset -> Active
    c = cyc; line = 2'd2;
    push(K_RES, c + 1, S_PWR);
    tick(1); line = 2'd0;
    r0 = c + RST + 2;
    push(K_RST, r0, S_ACT);
    wait_until(r0 + 3);
    check(st == 3'(S_ACT), "R4", st, S_ACT);

    // R11: broken SE0 restarts the count; R4 reset from Active
    c = cyc; line = 2'd1;
    tick(1); line = 2'd0;
    wait_until(c + RST); line = 2'd1;
    tick(1); line = 2'd0;
    c2 = c + RST + 1;
    push(K_RST, c2 + RST + 1, S_ACT);
    push(K_LOST, r0 + HL + 1, S_ACT);   // R7 with no frame strobes
    wait_until(c2 + RST + 3);
    line = 2'd2;
    wait_until(r0 + HL + 3);
    check(st == 3'(S_ACT), "R7", st, S_ACT);

    // R8/R9: frame strobe, pulse and valid, then timeout
    c = cyc; sof = 1;
    tick(1); sof = 0;
    check(rpulse && rvalid, "R8", {rpulse, rvalid}, 3);
    push(K_LOST, c + HL + 2, S_ACT);
    tick(1);
    check(!rpulse && rvalid, "R8", {rpulse, rvalid}, 1);
    wait_until(c + RL + 1);
    check(rvalid, "R9", rvalid, 1);
    tick(1);
    check(!rvalid, "R9", rvalid, 0);
    wait_until(c + HL + 3);
    check(!rvalid, "R9", rvalid, 0);
    c = cyc; sof = 1;
    tick(1); sof = 0;
    check(rpulse && rvalid, "R9", {rpulse, rvalid}, 3);
    // R10: disable blocks pulse and clears valid
    tick(1); rdis = 1;
    tick(1); sof = 1;
    c3 = cyc;
    tick(1); sof = 0;
    check(!rpulse && !rvalid, "R10", {rpulse, rvalid}, 0);
    tick(1); rdis = 0;
    tick(1);
    check(!rvalid, "R10", rvalid, 0);
    push(K_LOST, c3 + HL + 2, S_ACT);
    wait_until(c3 + HL + 3);

    // R5 from Active, then R6 via SE0 and R4 / R7 afterwards
    c = cyc; line = 2'd1;
    push(K_SUS, c + SUS + 1, S_SUS);
    wait_until(c + SUS + 3);
    check(st == 3'(S_SUS), "R5", st, S_SUS);
    c2 = cyc; line = 2'd0;
    push(K_RES, c2 + 1, S_ACT);
    push(K_RST, c2 + RST + 1, S_ACT);
    push(K_LOST, c2 + HL + 2, S_ACT);
    wait_until(c2 + RST + 2); line = 2'd2;
    wait_until(c2 + HL + 3);

    // R2: sense loss, then enable loss
    c = cyc; sense = 0;
    push(K_DISC, c + 1, S_DISC);
    tick(5);
    check(st == 3'(S_DISC), "R2", st, S_DISC);
    sense = 1;
    tick(3);
    check(st == 3'(S_PWR), "R3", st, S_PWR);
    c = cyc; enable = 0;
    push(K_DISC, c + 1, S_DISC);
    tick(6);
    check(st == 3'(S_DISC), "R2", st, S_DISC);
    check(exp_q.size() == 0, "R11", exp_q.size(), 0);
    finish_run();
  end
endmodule